// File: doc/BRIEF.md
# Eight-Pin I/O Port with Timer Compare Override

This block controls eight general-purpose pins from a small register interface. Software sets a direction bit, a reduced-drive bit and an output data bit for each pin. The block turns these settings into an output enable, an output level and a drive-strength select for each pad. Each pad input is passed through a two-flop synchronizer before software can read it back.

A timer output-compare channel can take over any pin. While its enable is high, the pin is driven as an output and carries the timer's compare level. The direction bit that software stored is left as it was. When the enable drops, the pin follows that stored bit again. The timer's input-capture tap is wired straight to the pad level, so it does not depend on direction or override.

Register access uses a one-cycle write strobe, a 2-bit select and 8-bit data. Reads are combinational from the selected register.

Top module: `gpio8_port`

## Requirements
- R1: After reset the data, direction and reduced-drive registers are all zero, so every pin is an input: pad_oe = 0x00, pad_out = 0x00 and pad_lowdrv = 0x00.
- R2: With no timer override on a pin, pad_oe for that pin equals its stored direction bit (1 = output, 0 = high-impedance input).
- R3: A write with reg_we high updates the register chosen by reg_sel at the next clock edge. The select codes are 0 = data, 1 = direction and 2 = reduced drive. Reads of codes 1 and 2 return the stored register unchanged, at any time.
- R4: While tmr_oc_en[i] is high, pad_oe[i] is 1 and pad_out[i] equals tmr_oc_val[i]. The stored direction bit, read with select code 1, is not changed by this.
- R5: When tmr_oc_en[i] goes low, pad_oe[i] and pad_out[i] follow the stored direction bit and data bit again in the same cycle.
- R6: tmr_ic_tap equals pin_in at all times, whatever the direction and override settings.
- R7: Select code 3 reads the synchronized pin level. A pin value present at clock edge k appears on reg_rdata after edge k+1. A write to code 3 changes nothing.
- R8: A read with select code 0 returns, per pin, the data register bit where pad_oe is 1 and the synchronized pin level where pad_oe is 0.
- R9: pad_lowdrv equals the reduced-drive register, one bit per pin.
- R10: With no timer override on a pin, pad_out for that pin equals its data register bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Single-cycle register write strobe |
| reg_sel | input | 2 | Register select: 0 data, 1 direction, 2 reduced drive, 3 pin level |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data of the selected register |
| tmr_oc_en | input | 8 | Per-pin timer output-compare enable (override) |
| tmr_oc_val | input | 8 | Per-pin timer compare output level |
| pin_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output level |
| pad_lowdrv | output | 8 | Per-pin reduced-drive select |
| tmr_ic_tap | output | 8 | Pad levels for the timer input capture |

## Verification
A direction write and a timer override can act on the same pin in the same cycle. The stored bit changes, but pad_oe must stay forced while the override holds. Random stimulus toggles tmr_oc_en and writes to the direction register on common cycles. Each time, the bench checks pad_oe, pad_out and the code-1 readback against a reference model. A second collision is a pin changing direction while its level is still in the synchronizer. Random pin changes mixed with direction writes check the code-0 read across that two-cycle window.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;
    localparam int unsigned PIN_W  = 8;
    localparam int unsigned SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA  = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_DRIVE = 2'd2,
        SEL_PINS  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PIN_W-1:0] data;
        logic [PIN_W-1:0] dir;
        logic [PIN_W-1:0] drive;
    } port_regs_t;
endpackage

// File: rtl/gpio8_regs.sv
module gpio8_regs
    import gpio8_pkg::*;
#(
    parameter int unsigned W = PIN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     data_o,
    output logic [W-1:0]     dir_o,
    output logic [W-1:0]     drive_o
);
    typedef struct packed {
        logic [W-1:0] data;
        logic [W-1:0] dir;
        logic [W-1:0] drive;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (we) begin
            unique case (reg_sel_e'(sel))
                SEL_DATA:  state_d.data  = wdata;
                SEL_DIR:   state_d.dir   = wdata;
                SEL_DRIVE: state_d.drive = wdata;
                default:   state_d       = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign data_o  = state_q.data;
    assign dir_o   = state_q.dir;
    assign drive_o = state_q.drive;
endmodule

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/gpio8_pinmux.sv
module gpio8_pinmux #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] ovr_en_i,
    input  logic [W-1:0] ovr_val_i,
    output logic [W-1:0] oe_o,
    output logic [W-1:0] out_o
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        always_comb begin
            if (ovr_en_i[p]) begin
                oe_o[p]  = 1'b1;
                out_o[p] = ovr_val_i[p];
            end else begin
                oe_o[p]  = dir_i[p];
                out_o[p] = data_i[p];
            end
        end
    end
endmodule

// File: rtl/gpio8_port.sv
module gpio8_port
    import gpio8_pkg::*;
#(
    parameter int unsigned W           = PIN_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [W-1:0]     reg_wdata,
    output logic [W-1:0]     reg_rdata,
    input  logic [W-1:0]     tmr_oc_en,
    input  logic [W-1:0]     tmr_oc_val,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     pad_oe,
    output logic [W-1:0]     pad_out,
    output logic [W-1:0]     pad_lowdrv,
    output logic [W-1:0]     tmr_ic_tap
);
    logic [W-1:0] data_q, dir_q, drive_q, pin_sync;

    gpio8_regs #(.W(W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .data_o  (data_q),
        .dir_o   (dir_q),
        .drive_o (drive_q)
    );

    gpio8_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync)
    );

    gpio8_pinmux #(.W(W)) i_mux (
        .dir_i     (dir_q),
        .data_i    (data_q),
        .ovr_en_i  (tmr_oc_en),
        .ovr_val_i (tmr_oc_val),
        .oe_o      (pad_oe),
        .out_o     (pad_out)
    );

    assign pad_lowdrv = drive_q;
    assign tmr_ic_tap = pin_in;

    always_comb begin
        unique case (reg_sel_e'(reg_sel))
            SEL_DATA:  reg_rdata = (pad_oe & data_q) | (~pad_oe & pin_sync);
            SEL_DIR:   reg_rdata = dir_q;
            SEL_DRIVE: reg_rdata = drive_q;
            default:   reg_rdata = pin_sync;
        endcase
    end
endmodule

// File: rtl/gpio8_port_chk.sv
module gpio8_port_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         reg_we,
    input logic [1:0]   reg_sel,
    input logic [W-1:0] reg_wdata,
    input logic [W-1:0] tmr_oc_en,
    input logic [W-1:0] tmr_oc_val,
    input logic [W-1:0] pin_in,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_lowdrv,
    input logic [W-1:0] tmr_ic_tap,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] pin_sync
);
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R4
    ovr_forces_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_oc_en & ~pad_oe) == '0);

    // R4
    ovr_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_oc_en & (pad_out ^ tmr_oc_val)) == '0);

    // R2
    dir_controls_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (~tmr_oc_en & (pad_oe ^ dir_q)) == '0);

    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 2'd1) |=> (dir_q == $past(reg_wdata)));

    // R4
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_sel == 2'd1) |=> $stable(dir_q));

    // R9
    drive_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 2'd2) |=> (pad_lowdrv == $past(reg_wdata)));

    // R6
    tap_follows_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ic_tap == pin_in);

    // R7
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (pin_sync == $past(pin_in, 2)));
endmodule

bind gpio8_port gpio8_port_chk #(.W(W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .tmr_oc_en  (tmr_oc_en),
    .tmr_oc_val (tmr_oc_val),
    .pin_in     (pin_in),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pad_lowdrv (pad_lowdrv),
    .tmr_ic_tap (tmr_ic_tap),
    .dir_q      (dir_q),
    .pin_sync   (pin_sync)
);

// File: tb/test_gpio8_port.sv
module test_gpio8_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] tmr_oc_en = '0;
    logic [7:0] tmr_oc_val = '0;
    logic [7:0] pin_in = '0;
    logic [7:0] pad_oe, pad_out, pad_lowdrv, tmr_ic_tap;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference state built from the requirements
    logic [7:0] m_data, m_dir, m_drv, m_s1, m_s2;

    always #10 clk = ~clk;

    gpio8_port i_gpio8_port (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tmr_oc_en(tmr_oc_en), .tmr_oc_val(tmr_oc_val), .pin_in(pin_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_lowdrv(pad_lowdrv),
        .tmr_ic_tap(tmr_ic_tap)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_data <= '0; m_dir <= '0; m_drv <= '0; m_s1 <= '0; m_s2 <= '0;
        end else begin
            m_s1 <= pin_in;
            m_s2 <= m_s1;
            if (reg_we) begin
                if (reg_sel == 2'd0) m_data <= reg_wdata;
                if (reg_sel == 2'd1) m_dir  <= reg_wdata;
                if (reg_sel == 2'd2) m_drv  <= reg_wdata;
            end
        end
    end

    function automatic logic [7:0] exp_oe();
        return m_dir | tmr_oc_en;
    endfunction

    function automatic logic [7:0] exp_out();
        return (tmr_oc_en & tmr_oc_val) | (~tmr_oc_en & m_data);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [1:0] s);
        logic [7:0] oe;
        oe = exp_oe();
        case (s)
            2'd0:    return (oe & m_data) | (~oe & m_s2);
            2'd1:    return m_dir;
            2'd2:    return m_drv;
            default: return m_s2;
        endcase
    endfunction

    task automatic cmp(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        cmp("R2/R4/R5", {tag, " pad_oe"}, pad_oe, exp_oe());
        cmp("R4/R10", {tag, " pad_out"}, pad_out, exp_out());
        cmp("R9", {tag, " pad_lowdrv"}, pad_lowdrv, m_drv);
        cmp("R6", {tag, " tap"}, tmr_ic_tap, pin_in);
        if (reg_sel == 2'd0) cmp("R8", {tag, " rd data"}, reg_rdata, exp_rd(2'd0));
        else if (reg_sel == 2'd3) cmp("R7", {tag, " rd pins"}, reg_rdata, exp_rd(2'd3));
        else cmp("R3", {tag, " rd reg"}, reg_rdata, exp_rd(reg_sel));
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] s, input logic [7:0] exp, input string req);
        reg_sel = s;
        #1;
        cmp(req, "directed read", reg_rdata, exp);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000 && !done) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected < 50000", cycles);
                $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        #35 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        cmp("R1", "reset pad_oe", pad_oe, 8'h00);
        cmp("R1", "reset pad_out", pad_out, 8'h00);
        cmp("R1", "reset pad_lowdrv", pad_lowdrv, 8'h00);
        rd_chk(2'd1, 8'h00, "R1");
        rd_chk(2'd2, 8'h00, "R1");

        // R3 and R2: direction write, then readback
        wr(2'd1, 8'hA5);
        rd_chk(2'd1, 8'hA5, "R3");
        cmp("R2", "dir drives oe", pad_oe, 8'hA5);
        wr(2'd0, 8'h3C);
        cmp("R10", "data drives out", pad_out, 8'h3C);
        wr(2'd2, 8'h0F);
        cmp("R9", "lowdrv", pad_lowdrv, 8'h0F);

        // R7: writing code 3 changes no register
        wr(2'd3, 8'hFF);
        rd_chk(2'd0 + 2'd1, 8'hA5, "R7");
        rd_chk(2'd2, 8'h0F, "R7");
        cmp("R7", "data after code-3 write", pad_out, 8'h3C);

        // R7: sync latency, pin change seen after two edges
        pin_in = 8'h5A; reg_sel = 2'd3;
        @(negedge clk);
        cmp("R7", "one edge, not yet", reg_rdata, 8'h00);
        @(negedge clk);
        cmp("R7", "two edges, visible", reg_rdata, 8'h5A);

        // R4: override forces output, stored direction unchanged
        @(negedge clk);
        tmr_oc_en = 8'hFF; tmr_oc_val = 8'h81;
        #1;
        cmp("R4", "override oe", pad_oe, 8'hFF);
        cmp("R4", "override out", pad_out, 8'h81);
        rd_chk(2'd1, 8'hA5, "R4");
        // R4: direction write during override
        wr(2'd1, 8'h00);
        cmp("R4", "oe held while forced", pad_oe, 8'hFF);
        // R5: release returns to stored bits
        tmr_oc_en = 8'h00;
        #1;
        cmp("R5", "release oe", pad_oe, 8'h00);
        cmp("R5", "release out", pad_out, 8'h3C);
        // R8: all inputs -> synced pins
        rd_chk(2'd0, 8'h5A, "R8");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            reg_we     = ($urandom % 3) == 0;
            reg_sel    = 2'($urandom);
            reg_wdata  = 8'($urandom);
            tmr_oc_en  = ($urandom % 2) ? 8'($urandom) : 8'h00;
            tmr_oc_val = 8'($urandom);
            if ($urandom % 4 == 0) pin_in = 8'($urandom);
            #2;
            check_all("rand");
        end
        reg_we = 1'b0;
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule